// File: doc/BRIEF.md
# Parity-Constrained Constituent Code Decoder

This block decodes one constituent code of a tree-pruned polar decoder in which only the leftmost leaf is frozen. Every other leaf carries information. The frozen leaf forces the decoded vector to have even parity. The block takes `N` signed log-likelihood ratios together with a start pulse. It produces `N` hard decisions that always have even parity, and it marks them with a one-cycle done strobe.

The decoding rule works in four steps:
- Each LLR is sliced to a bit from its sign.
- The parity of those bits is computed.
- A pipelined comparator tree finds the position whose LLR has the smallest magnitude.
- If the parity is odd, the bit at that position is inverted.

The block is fully pipelined, so a new vector may be started on every cycle. Each result appears a fixed number of cycles later. Classifying nodes and building partial sums for the parent are handled outside this block.

Top module: `spc_node_decoder`

## Requirements
- R1: Output bit i is derived from the LLR at `llr_i[i*W +: W]` (two's complement). Its hard decision is 1 when that LLR is negative and 0 when it is zero or positive.
- R2: When the XOR of all hard decisions is 0, `bits_o` equals the hard decisions unchanged.
- R3: When the XOR of all hard decisions is 1, `bits_o` differs from the hard decisions in exactly one position. That position holds the LLR of smallest magnitude.
- R4: When several positions share the smallest magnitude, the one with the lowest index is inverted.
- R5: The magnitude of the most negative LLR value (-2^(W-1)) is taken as 2^(W-1)-1, the largest positive magnitude.
- R6: `done_o` is high for exactly one cycle, log2(N)+1 cycles after each cycle in which `start_i` is high. Starts on consecutive cycles give done pulses on consecutive cycles, in the same order.
- R7: Whenever `done_o` is high, the XOR of all bits of `bits_o` is 0.
- R8: While `rst` is high and in the cycle after it is released, `done_o` is 0 and `bits_o` is all zeros.
- R9: `bits_o` changes only in a cycle where `done_o` is high. LLR values presented without `start_i` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sample `llr_i` this cycle and decode it |
| llr_i | input | N*W | N two's-complement LLRs, position i in bits `[i*W +: W]` |
| bits_o | output | N | Decoded bits, held until the next result |
| done_o | output | 1 | One-cycle strobe marking a new `bits_o` |

## Verification
The bench builds the block with N=4 and W=4, giving 16 bits of input and a pipeline three stages deep. That size allows every one of the 65,536 LLR combinations to be streamed back to back. The sweep therefore reaches every tie pattern, every placement of the saturating value -8, and both parity outcomes. Short directed sequences around the sweep cover the reset state, the exact latency of an isolated start, and the output holding still while the inputs change without a start.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int unsigned SPC_N_DEF = 8;
    localparam int unsigned SPC_W_DEF = 6;

    // Control word carried alongside each vector through the pipeline.
    typedef struct packed {
        logic valid;
        logic parity;
    } stage_ctl_t;

    // Number of comparator levels for a power-of-two input count.
    function automatic int unsigned tree_levels(input int unsigned n);
        return $clog2(n);
    endfunction

endpackage

// File: rtl/spc_leaf.sv
// Sign slicer and saturating magnitude for one LLR.
module spc_leaf #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] llr_i,
    output logic         hard_o,
    output logic [W-2:0] mag_o
);
    always_comb begin
        hard_o = llr_i[W-1];
        if (!llr_i[W-1]) begin
            mag_o = llr_i[W-2:0];
        end else if (llr_i[W-2:0] == '0) begin
            mag_o = '1;
        end else begin
            mag_o = (~llr_i[W-2:0]) + 1'b1;
        end
    end
endmodule

// File: rtl/spc_pick2.sv
// One comparator cell: the right operand wins only when strictly smaller.
module spc_pick2 #(
    parameter int unsigned MW = 5,
    parameter int unsigned IW = 3
) (
    input  logic [MW-1:0] a_mag_i,
    input  logic [IW-1:0] a_idx_i,
    input  logic [MW-1:0] b_mag_i,
    input  logic [IW-1:0] b_idx_i,
    output logic [MW-1:0] mag_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        if (b_mag_i < a_mag_i) begin
            mag_o = b_mag_i;
            idx_o = b_idx_i;
        end else begin
            mag_o = a_mag_i;
            idx_o = a_idx_i;
        end
    end
endmodule

// File: rtl/spc_flip.sv
// Conditional single-bit correction.
module spc_flip #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  hard_i,
    input  logic          odd_i,
    input  logic [IW-1:0] idx_i,
    output logic [N-1:0]  bits_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign bits_o[i] = hard_i[i] ^ (odd_i & (idx_i == IW'(i)));
    end
endmodule

// File: rtl/spc_node_decoder.sv
module spc_node_decoder
    import spc_pkg::*;
#(
    parameter int unsigned N = SPC_N_DEF,
    parameter int unsigned W = SPC_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [N*W-1:0] llr_i,
    output logic [N-1:0]   bits_o,
    output logic           done_o
);
    localparam int unsigned LVL = tree_levels(N);
    localparam int unsigned MW  = W - 1;
    localparam int unsigned IW  = (LVL < 1) ? 1 : LVL;

    // Leaf slicing, combinational from the inputs.
    logic [N-1:0]  sgn_c;
    logic [MW-1:0] leaf_mag_c [N];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        spc_leaf #(.W(W)) u_leaf (
            .llr_i (llr_i[i*W +: W]),
            .hard_o(sgn_c[i]),
            .mag_o (leaf_mag_c[i])
        );
    end

    // Heap-ordered comparator tree: node k has children 2k and 2k+1,
    // with leaves at N..2N-1. Each node's result is registered.
    logic [MW-1:0] pick_mag   [1:N-1];
    logic [IW-1:0] pick_idx   [1:N-1];
    logic [MW-1:0] node_mag_q [1:N-1];
    logic [IW-1:0] node_idx_q [1:N-1];

    for (genvar k = 1; k < N; k++) begin : g_node
        logic [MW-1:0] a_mag, b_mag;
        logic [IW-1:0] a_idx, b_idx;
        if (2*k >= N) begin : g_from_leaf
            assign a_mag = leaf_mag_c[2*k - N];
            assign a_idx = IW'(2*k - N);
            assign b_mag = leaf_mag_c[2*k + 1 - N];
            assign b_idx = IW'(2*k + 1 - N);
        end else begin : g_from_node
            assign a_mag = node_mag_q[2*k];
            assign a_idx = node_idx_q[2*k];
            assign b_mag = node_mag_q[2*k + 1];
            assign b_idx = node_idx_q[2*k + 1];
        end
        spc_pick2 #(.MW(MW), .IW(IW)) u_pick (
            .a_mag_i(a_mag),
            .a_idx_i(a_idx),
            .b_mag_i(b_mag),
            .b_idx_i(b_idx),
            .mag_o  (pick_mag[k]),
            .idx_o  (pick_idx[k])
        );
    end

    always_ff @(posedge clk) begin
        for (int k = 1; k < int'(N); k++) begin
            node_mag_q[k] <= pick_mag[k];
            node_idx_q[k] <= pick_idx[k];
        end
    end

    // Decisions and control travel beside the tree, one stage per level.
    logic [N-1:0] hard_q [1:LVL];
    stage_ctl_t   ctl_q  [1:LVL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 1; s <= int'(LVL); s++) begin
                ctl_q[s] <= '0;
            end
        end else begin
            ctl_q[1] <= '{valid: start_i, parity: ^sgn_c};
            for (int s = 2; s <= int'(LVL); s++) begin
                ctl_q[s] <= ctl_q[s-1];
            end
        end
        hard_q[1] <= sgn_c;
        for (int s = 2; s <= int'(LVL); s++) begin
            hard_q[s] <= hard_q[s-1];
        end
    end

    // Final correction against the root of the tree.
    logic [N-1:0] fix_c;

    spc_flip #(.N(N), .IW(IW)) u_flip (
        .hard_i(hard_q[LVL]),
        .odd_i (ctl_q[LVL].parity),
        .idx_i (node_idx_q[1]),
        .bits_o(fix_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= ctl_q[LVL].valid;
            if (ctl_q[LVL].valid) begin
                bits_o <= fix_c;
            end
        end
    end
endmodule

// File: rtl/spc_node_decoder_chk.sv
module spc_node_decoder_chk #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic [N*W-1:0] llr_i,
    input logic [N-1:0]   bits_o,
    input logic           done_o
);
    localparam int unsigned LVL = $clog2(N);

    logic [LVL:0] st_sr;
    logic [N-1:0] sgn_sr [0:LVL];
    logic [N-1:0] sgn_now;

    for (genvar i = 0; i < N; i++) begin : g_sgn
        assign sgn_now[i] = llr_i[i*W + W - 1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_sr <= '0;
        end else begin
            st_sr <= {st_sr[LVL-1:0], start_i};
        end
        sgn_sr[0] <= sgn_now;
        for (int s = 1; s <= int'(LVL); s++) begin
            sgn_sr[s] <= sgn_sr[s-1];
        end
    end

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o == st_sr[LVL]);

    // R7
    even_parity_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (^bits_o) == 1'b0);

    // R3
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $countones(bits_o ^ sgn_sr[LVL]) <= 1);

    // R2
    even_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && ((^sgn_sr[LVL]) == 1'b0)) |-> bits_o == sgn_sr[LVL]);

    // R9
    hold_output_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(bits_o));
endmodule

bind spc_node_decoder spc_node_decoder_chk #(.N(N), .W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .llr_i  (llr_i),
    .bits_o (bits_o),
    .done_o (done_o)
);

// File: tb/spc_node_decoder_tb.sv
module spc_node_decoder_tb;
    localparam int unsigned N = 4;
    localparam int unsigned W = 4;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY = 3;
    localparam int NVEC = 65536;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [N*W-1:0] llr_i = '0;
    logic [N-1:0]   bits_o;
    logic           done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spc_node_decoder #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .llr_i(llr_i), .bits_o(bits_o), .done_o(done_o)
    );

    function automatic int sat_mag(input logic [3:0] x);
        int v;
        v = int'($signed(x));
        if (v < 0) v = -v;
        if (v > 7) v = 7;
        return v;
    endfunction

    function automatic logic [3:0] ref_bits(input logic [15:0] v);
        logic [3:0] h;
        int best, bm;
        best = 0;
        bm = sat_mag(v[3:0]);
        for (int i = 0; i < 4; i++) begin
            h[i] = v[4*i+3];
            if (sat_mag(v[4*i +: 4]) < bm) begin
                bm = sat_mag(v[4*i +: 4]);
                best = i;
            end
        end
        if (^h) h[best] = ~h[best];
        return h;
    endfunction

    function automatic string tag_of(input logic [15:0] v);
        logic [3:0] h;
        int bm, nmin;
        bm = 99;
        nmin = 0;
        for (int i = 0; i < 4; i++) begin
            h[i] = v[4*i+3];
            if (sat_mag(v[4*i +: 4]) < bm) bm = sat_mag(v[4*i +: 4]);
        end
        for (int i = 0; i < 4; i++) if (sat_mag(v[4*i +: 4]) == bm) nmin++;
        for (int i = 0; i < 4; i++) if (v[4*i +: 4] == 4'h8) return "R5";
        if (!(^h)) return "R2";
        if (nmin > 1) return "R4";
        return "R3";
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Single isolated decode; returns result and measured latency.
    task automatic run_one(input logic [15:0] v, output logic [3:0] res, output int lat);
        @(negedge clk);
        llr_i = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        res = bits_o;
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] res;
        logic [3:0] held;
        int lat;
        int rx;

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 done in reset", 32'(done_o), 0);
        check("R8 bits in reset", 32'(bits_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 done after reset", 32'(done_o), 0);
        check("R8 bits after reset", 32'(bits_o), 0);

        // R1 and R6: signs {+0,-1,+3,-2}, even parity, latency and pulse width
        run_one(16'hE_3_F_0, res, lat);
        check("R1 sign slicing", 32'(res), 32'(4'b1010));
        check("R6 latency", 32'(lat), LATENCY);
        @(negedge clk);
        check("R6 single-cycle done", 32'(done_o), 0);

        // R5: value -8 at index 1 among magnitude-7 values: index 0 flipped
        run_one(16'h7_7_8_7, res, lat);
        check("R5 saturated magnitude", 32'(res), 32'(4'b0011));

        // R4: equal magnitudes, odd parity, lowest index flipped
        run_one(16'h3_3_3_D, res, lat);
        check("R4 tie lowest index", 32'(res), 32'(4'b0000));

        // R3: unique minimum at index 2
        run_one(16'h5_1_A_6, res, lat);
        check("R3 least reliable flip", 32'(res), 32'(ref_bits(16'h5_1_A_6)));

        // R9: inputs change without start, output holds
        held = bits_o;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            llr_i = 16'h9AB3 + 16'(c * 4097);
            check("R9 done stays low", 32'(done_o), 0);
            check("R9 bits held", 32'(bits_o), 32'(held));
        end

        // Exhaustive back-to-back sweep (R2, R3, R4, R5, R6, R7)
        rx = 0;
        fork
            begin
                for (int v = 0; v < NVEC; v++) begin
                    @(negedge clk);
                    llr_i = 16'(v);
                    start_i = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
            end
            begin
                while (rx < NVEC) begin
                    @(negedge clk);
                    if (done_o) begin
                        check(tag_of(16'(rx)), 32'(bits_o), 32'(ref_bits(16'(rx))));
                        check("R7 even output parity", 32'(^bits_o), 0);
                        rx++;
                    end
                end
            end
        join
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check("R6 no extra done", 32'(done_o), 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule